// File: doc/BRIEF.md
# Monochrome Panel Raster Scan-Out

This block turns a page-organised one-bit framebuffer into a raster pixel stream for a small monochrome panel. The framebuffer holds 8 pages of 132 byte-wide columns. Each byte carries eight vertically stacked pixels. The visible area is 96 columns by 16 rows. A magnification factor repeats each pixel horizontally and each line vertically, so the default output is 384 by 64 pixels.

The framebuffer is external. The block drives a read port and expects the data one cycle after the read enable. Each source bit becomes a 24-bit colour word. A lit pixel is all ones and a dark pixel is all zeros, and two display flags (force-all-lit and invert) decide which source value is lit.

No frame is produced unless a redraw has been requested. The request stays pending while the frame is in flight and clears when the last pixel has been accepted. A sink-side ready input stalls the stream without losing pixels.

Top module: `oled_scanout`

## Requirements
- R1: While rst is high and in the cycle after it falls, pix_valid, frame_start, line_start, fb_rd_en and redraw_pending are low and pix_rgb is zero.
- R2: A one-cycle pulse on redraw_req raises redraw_pending at the next clock edge. While redraw_pending is low, neither fb_rd_en nor pix_valid is ever high.
- R3: A frame consists of exactly (96·MAG) × (16·MAG) accepted pixels in row-major order. Each source pixel is repeated MAG times along a line, and each source line MAG times in consecutive output lines.
- R4: Output pixel (x, y) shows source column c = x/MAG and source row r = y/MAG. It takes line L = (r + start_line) mod 64, reads the byte at address (L>>3)·132 + c + 36, and uses bit (L & 7) of that byte, where bit 0 is the top line of a page. Read data is used one cycle after fb_rd_en, and the port holds it while fb_rd_en is low. Every read address falls in columns 36..131 of its page.
- R5: A pixel is lit when entire_on is 1. Otherwise it is lit when the source bit XOR inverse is 1. A lit pixel gives pix_rgb = 24'hFFFFFF, and a dark pixel gives 24'h000000.
- R6: frame_start is high with the first pixel of a frame only. line_start is high with the first pixel of every output line only. Both are high only while pix_valid is high.
- R7: While pix_valid is high and out_ready is low, pix_valid, pix_rgb and the strobes hold their values at the next edge. No pixel is dropped or repeated.
- R8: start_line, entire_on and inverse are sampled when a frame begins. Changes made during a frame have no effect until the next frame.
- R9: redraw_pending falls after the last pixel of the frame is accepted. A redraw_req that arrives while a frame is in flight keeps redraw_pending high past that frame, and one further frame follows without another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redraw_req | input | 1 | One-cycle request for a new frame |
| start_line | input | 6 | Line offset into the 64 framebuffer lines |
| entire_on | input | 1 | Force every pixel lit |
| inverse | input | 1 | Invert source bits |
| out_ready | input | 1 | Sink accepts the current pixel |
| fb_rd_data | input | 8 | Framebuffer byte, one cycle after fb_rd_en |
| redraw_pending | output | 1 | A frame is owed or in flight |
| fb_rd_en | output | 1 | Framebuffer read enable |
| fb_rd_addr | output | 11 | Framebuffer byte address |
| pix_valid | output | 1 | pix_rgb holds a pixel |
| pix_rgb | output | 24 | Pixel colour |
| frame_start | output | 1 | First pixel of a frame |
| line_start | output | 1 | First pixel of an output line |

## Verification
The hardest state to reach is a redraw request, together with changed display flags and start line, arriving in the middle of a frame whose reads are already stalled by backpressure. The bench gets there by waiting until the checker-side raster position passes a chosen output line. It then changes start_line and inverse and pulses redraw_req. Every pixel of that frame must still follow the old settings, and a second frame must follow on its own with the new ones. Stall patterns from a small LFSR on out_ready cover the hold-and-resume path, and a start line near 64 covers the wrap of the line index.

// File: rtl/oled_scan_pkg.sv
package oled_scan_pkg;

  // width of a counter or index for n values, never zero
  function automatic int cw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // one-bit shading: force-on dominates, otherwise optional invert
  function automatic logic pix_lit(input logic [7:0] col_byte, input logic [2:0] bit_sel,
                                   input logic all_on, input logic invert);
    return all_on | (col_byte[bit_sel] ^ invert);
  endfunction

endpackage

// File: rtl/oled_scan_addr.sv
module oled_scan_addr
  import oled_scan_pkg::*;
#(
  parameter int FB_COLS  = 132,
  parameter int FB_PAGES = 8,
  parameter int VIS_W    = 96,
  parameter int VIS_H    = 16,
  parameter int COL_OFS  = 36,
  parameter int MAG      = 4,
  parameter int LINE_W   = cw(FB_PAGES * 8),
  parameter int ADDR_W   = cw(FB_COLS * FB_PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  input  logic [LINE_W-1:0] start_line,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        bit_sel,
  output logic              first,
  output logic              line_first,
  output logic              last
);
  localparam int LINES = FB_PAGES * 8;
  localparam int SUB_W = cw(MAG);
  localparam int XC_W  = cw(VIS_W);
  localparam int YR_W  = cw(VIS_H);
  localparam int LW1   = LINE_W + 1;

  logic [SUB_W-1:0] xs_q, ys_q;
  logic [XC_W-1:0]  xc_q;
  logic [YR_W-1:0]  yr_q;
  logic xs_end, xc_end, ys_end, yr_end;
  logic [LW1-1:0]    line_sum;
  logic [LINE_W-1:0] line_idx;

  assign xs_end = (xs_q == SUB_W'(MAG - 1));
  assign xc_end = (xc_q == XC_W'(VIS_W - 1));
  assign ys_end = (ys_q == SUB_W'(MAG - 1));
  assign yr_end = (yr_q == YR_W'(VIS_H - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      xs_q <= '0;
      xc_q <= '0;
      ys_q <= '0;
      yr_q <= '0;
    end else if (step) begin
      xs_q <= xs_end ? '0 : xs_q + 1'b1;
      if (xs_end) begin
        xc_q <= xc_end ? '0 : xc_q + 1'b1;
        if (xc_end) begin
          ys_q <= ys_end ? '0 : ys_q + 1'b1;
          if (ys_end) yr_q <= yr_end ? '0 : yr_q + 1'b1;
        end
      end
    end
  end

  // source line wraps around the framebuffer height
  always_comb begin
    line_sum = LW1'(yr_q) + LW1'(start_line);
    if (line_sum >= LW1'(LINES)) line_sum = line_sum - LW1'(LINES);
    line_idx = line_sum[LINE_W-1:0];
  end

  assign bit_sel    = line_idx[2:0];
  assign rd_addr    = ADDR_W'(line_idx[LINE_W-1:3]) * ADDR_W'(FB_COLS)
                    + ADDR_W'(xc_q) + ADDR_W'(COL_OFS);
  assign line_first = (xs_q == '0) && (xc_q == '0);
  assign first      = line_first && (ys_q == '0) && (yr_q == '0);
  assign last       = xs_end && xc_end && ys_end && yr_end;

endmodule

// File: rtl/oled_pix_shade.sv
module oled_pix_shade
  import oled_scan_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [2:0]       in_bit,
  input  logic             all_on,
  input  logic             invert,
  input  logic             in_first,
  input  logic             in_line_first,
  input  logic             in_last,
  output logic             out_valid,
  output logic [RGB_W-1:0] out_rgb,
  output logic             out_first,
  output logic             out_line_first,
  output logic             out_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_rgb        <= '0;
      out_first      <= 1'b0;
      out_line_first <= 1'b0;
      out_last       <= 1'b0;
    end else if (load) begin
      out_valid      <= in_valid;
      out_rgb        <= (in_valid && pix_lit(in_byte, in_bit, all_on, invert)) ? '1 : '0;
      out_first      <= in_valid && in_first;
      out_line_first <= in_valid && in_line_first;
      out_last       <= in_valid && in_last;
    end
  end

endmodule

// File: rtl/oled_scanout.sv
module oled_scanout
  import oled_scan_pkg::*;
#(
  parameter int FB_COLS  = 132,
  parameter int FB_PAGES = 8,
  parameter int VIS_W    = 96,
  parameter int VIS_H    = 16,
  parameter int COL_OFS  = 36,
  parameter int MAG      = 4,
  parameter int RGB_W    = 24,
  parameter int LINE_W   = cw(FB_PAGES * 8),
  parameter int ADDR_W   = cw(FB_COLS * FB_PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redraw_req,
  input  logic [LINE_W-1:0] start_line,
  input  logic              entire_on,
  input  logic              inverse,
  input  logic              out_ready,
  input  logic [7:0]        fb_rd_data,
  output logic              redraw_pending,
  output logic              fb_rd_en,
  output logic [ADDR_W-1:0] fb_rd_addr,
  output logic              pix_valid,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              frame_start,
  output logic              line_start
);
  logic pend_q, again_q, busy_q, scan_q;
  logic [LINE_W-1:0] sl_q;
  logic ent_q, inv_q;
  logic advance, issue, begin_frame, frame_done;
  logic a_first, a_line_first, a_last;
  logic [2:0] a_bit;
  logic s1_valid, s1_first, s1_line_first, s1_last;
  logic [2:0] s1_bit;
  logic o_last;

  assign advance     = !pix_valid || out_ready;
  assign issue       = scan_q && advance;
  assign begin_frame = pend_q && !busy_q;
  assign frame_done  = pix_valid && out_ready && o_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      again_q <= 1'b0;
      busy_q  <= 1'b0;
      scan_q  <= 1'b0;
      sl_q    <= '0;
      ent_q   <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      if (frame_done) begin
        pend_q  <= again_q || redraw_req;
        again_q <= 1'b0;
        busy_q  <= 1'b0;
      end else begin
        if (redraw_req) pend_q <= 1'b1;
        if (redraw_req && busy_q) again_q <= 1'b1;
        if (begin_frame) busy_q <= 1'b1;
      end
      if (begin_frame) begin
        scan_q <= 1'b1;
        sl_q   <= start_line;
        ent_q  <= entire_on;
        inv_q  <= inverse;
      end else if (issue && a_last) begin
        scan_q <= 1'b0;
      end
    end
  end

  oled_scan_addr #(
    .FB_COLS(FB_COLS), .FB_PAGES(FB_PAGES), .VIS_W(VIS_W), .VIS_H(VIS_H),
    .COL_OFS(COL_OFS), .MAG(MAG), .LINE_W(LINE_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst(rst), .restart(begin_frame), .step(issue),
    .start_line(sl_q), .rd_addr(fb_rd_addr), .bit_sel(a_bit),
    .first(a_first), .line_first(a_line_first), .last(a_last)
  );

  assign fb_rd_en = issue;

  // stage aligned with the returning read data
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid      <= 1'b0;
      s1_bit        <= '0;
      s1_first      <= 1'b0;
      s1_line_first <= 1'b0;
      s1_last       <= 1'b0;
    end else if (advance) begin
      s1_valid      <= issue;
      s1_bit        <= a_bit;
      s1_first      <= a_first;
      s1_line_first <= a_line_first;
      s1_last       <= a_last;
    end
  end

  oled_pix_shade #(.RGB_W(RGB_W)) u_shade (
    .clk(clk), .rst(rst), .load(advance), .in_valid(s1_valid),
    .in_byte(fb_rd_data), .in_bit(s1_bit), .all_on(ent_q), .invert(inv_q),
    .in_first(s1_first), .in_line_first(s1_line_first), .in_last(s1_last),
    .out_valid(pix_valid), .out_rgb(pix_rgb), .out_first(frame_start),
    .out_line_first(line_start), .out_last(o_last)
  );

  assign redraw_pending = pend_q;

endmodule

// File: rtl/oled_scanout_chk.sv
module oled_scanout_chk #(
  parameter int FB_COLS = 132,
  parameter int VIS_W   = 96,
  parameter int COL_OFS = 36,
  parameter int RGB_W   = 24,
  parameter int ADDR_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              out_ready,
  input logic              redraw_pending,
  input logic              fb_rd_en,
  input logic [ADDR_W-1:0] fb_rd_addr,
  input logic              pix_valid,
  input logic [RGB_W-1:0]  pix_rgb,
  input logic              frame_start,
  input logic              line_start
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !out_ready) |=> (pix_valid && $stable(pix_rgb) && $stable(frame_start) && $stable(line_start))); // R7
  AST_RGB_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (pix_rgb == '0 || pix_rgb == '1)); // R5
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !redraw_pending |-> !fb_rd_en); // R2
  AST_IDLE_NO_PIX: assert property (@(posedge clk) disable iff (rst)
    !redraw_pending |-> !pix_valid); // R2
  AST_COL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    fb_rd_en |-> ((int'(fb_rd_addr) % FB_COLS) >= COL_OFS && (int'(fb_rd_addr) % FB_COLS) < COL_OFS + VIS_W)); // R4
  AST_STROBE_QUAL: assert property (@(posedge clk) disable iff (rst)
    (frame_start || line_start) |-> pix_valid); // R6
  AST_FRAME_IS_LINE: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start); // R6
endmodule

bind oled_scanout oled_scanout_chk #(
  .FB_COLS(FB_COLS), .VIS_W(VIS_W), .COL_OFS(COL_OFS), .RGB_W(RGB_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_oled_scanout.sv
module test_oled_scanout;
  localparam int FB_COLS = 132;
  localparam int PAGES   = 8;
  localparam int VW      = 96;
  localparam int VH      = 16;
  localparam int OFS     = 36;
  localparam int MAG     = 4;
  localparam int OW      = VW * MAG;
  localparam int OH      = VH * MAG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic redraw_req = 1'b0;
  logic [5:0] start_line = '0;
  logic entire_on = 1'b0;
  logic inverse = 1'b0;
  logic out_ready = 1'b1;
  logic [7:0] fb_rd_data = '0;
  logic redraw_pending, fb_rd_en, pix_valid, frame_start, line_start;
  logic [10:0] fb_rd_addr;
  logic [23:0] pix_rgb;

  always #4 clk = ~clk;

  oled_scanout i_oled_scanout (
    .clk(clk), .rst(rst), .redraw_req(redraw_req), .start_line(start_line),
    .entire_on(entire_on), .inverse(inverse), .out_ready(out_ready),
    .fb_rd_data(fb_rd_data), .redraw_pending(redraw_pending), .fb_rd_en(fb_rd_en),
    .fb_rd_addr(fb_rd_addr), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .frame_start(frame_start), .line_start(line_start)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // framebuffer model: registered read, holds data while not enabled
  logic [7:0] fbm [0:FB_COLS*PAGES-1];
  always @(posedge clk) if (fb_rd_en) fb_rd_data <= fbm[fb_rd_addr];

  task automatic fill_fb(input int seed);
    for (int i = 0; i < FB_COLS * PAGES; i++) fbm[i] = 8'((i * 37 + seed * 11) ^ (i >> 3) ^ seed);
  endtask

  // sink ready pattern
  bit stall_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  // expected settings per frame index
  int e_sl [0:7];
  bit e_ent [0:7];
  bit e_inv [0:7];
  int frames_seen = 0;
  int ex = 0;
  int ey = 0;
  bit hold_prev = 0;
  logic [23:0] prev_rgb = '0;

  function automatic bit exp_lit(input int px, input int py, input int sl, input bit ent, input bit inv);
    int col;
    int line;
    logic [7:0] b;
    col  = px / MAG;
    line = (py / MAG + sl) % (PAGES * 8);
    b    = fbm[(line / 8) * FB_COLS + col + OFS];
    if (ent) return 1'b1;
    return b[line % 8] ^ inv;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (!redraw_pending && (pix_valid || fb_rd_en))
        check(0, "R2 activity without pending", {pix_valid, fb_rd_en}, 0);
      if ((frame_start || line_start) && !pix_valid)
        check(0, "R6 strobe without valid", {frame_start, line_start}, 0);
      if (hold_prev)
        check(pix_valid && pix_rgb == prev_rgb, "R7 hold under stall", pix_rgb, prev_rgb);
      hold_prev = pix_valid && !out_ready;
      prev_rgb  = pix_rgb;
      if (pix_valid && out_ready) begin
        int fi;
        bit lit;
        fi  = (frames_seen > 7) ? 7 : frames_seen;
        lit = exp_lit(ex, ey, e_sl[fi], e_ent[fi], e_inv[fi]);
        check(pix_rgb == (lit ? 24'hFFFFFF : 24'h0), $sformatf("R4 R5 R8 pixel x=%0d y=%0d", ex, ey),
              pix_rgb, lit ? 24'hFFFFFF : 24'h0);
        check(frame_start == (ex == 0 && ey == 0), "R3 R6 frame_start", frame_start, ex == 0 && ey == 0);
        check(line_start == (ex == 0), "R6 line_start", line_start, ex == 0);
        ex++;
        if (ex == OW) begin
          ex = 0;
          ey++;
          if (ey == OH) begin
            ey = 0;
            frames_seen++;
          end
        end
      end
    end
  end

  task automatic pulse_req();
    @(negedge clk) redraw_req = 1'b1;
    @(negedge clk) redraw_req = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (frames_seen < target) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(!pix_valid && !frame_start && !line_start && !fb_rd_en && !redraw_pending && pix_rgb == 0,
          "R1 outputs in reset", {pix_valid, fb_rd_en, redraw_pending}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pix_valid && !fb_rd_en && !redraw_pending && pix_rgb == 0, "R1 outputs after reset",
          {pix_valid, fb_rd_en, redraw_pending}, 0);
    repeat (40) @(negedge clk);
    check(!redraw_pending && !pix_valid && frames_seen == 0, "R2 idle without request",
          {redraw_pending, pix_valid}, 0);
  endtask

  task automatic run_frame(input int sl, input bit ent, input bit inv, input bit stall, input int seed);
    int n;
    n = frames_seen;
    fill_fb(seed);
    e_sl[n] = sl; e_ent[n] = ent; e_inv[n] = inv;
    start_line = 6'(sl); entire_on = ent; inverse = inv;
    stall_mode = stall;
    pulse_req();
    check(redraw_pending == 1'b1, "R2 pending after request", redraw_pending, 1);
    wait_frames(n + 1);
    @(negedge clk);
    check(redraw_pending == 1'b0, "R9 pending cleared after frame", redraw_pending, 0);
    check(frames_seen == n + 1 && ex == 0 && ey == 0, "R3 frame pixel count", frames_seen, n + 1);
    repeat (20) @(negedge clk);
    check(!pix_valid && frames_seen == n + 1, "R2 no frame without new request", pix_valid, 0);
    stall_mode = 0;
  endtask

  task automatic t_midframe();
    int n;
    n = frames_seen;
    fill_fb(77);
    e_sl[n] = 5;  e_ent[n] = 0;   e_inv[n] = 0;
    e_sl[n+1] = 40; e_ent[n+1] = 0; e_inv[n+1] = 1;
    start_line = 6'd5; entire_on = 0; inverse = 0;
    stall_mode = 1;
    pulse_req();
    while (ey < 20) @(negedge clk);
    start_line = 6'd40; inverse = 1;   // R8: must not touch the current frame
    pulse_req();                       // R9: re-arm during the frame
    wait_frames(n + 1);
    @(negedge clk);
    check(redraw_pending == 1'b1, "R9 pending kept by mid-frame request", redraw_pending, 1);
    wait_frames(n + 2);
    @(negedge clk);
    check(redraw_pending == 1'b0, "R9 pending cleared after follow-up frame", redraw_pending, 0);
    check(frames_seen == n + 2, "R9 exactly one follow-up frame", frames_seen, n + 2);
    stall_mode = 0;
  endtask

  initial begin
    t_reset();
    run_frame(0, 0, 0, 0, 1);    // R3 R4 R5 plain
    run_frame(60, 0, 1, 1, 2);   // R4 wrap, R5 inverse, R7 stalls
    run_frame(17, 1, 1, 0, 3);   // R5 entire-on overrides inverse
    t_midframe();                // R8 R9
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", frames_seen, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule